// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between a console's CPU and picture-processor buses and the cartridge memories. It watches CPU writes in the upper half of the 16-bit CPU address space and captures them into bank-select and mirroring registers. From those registers it builds wide ROM addresses combinationally. The CPU side sees one switchable 16 KiB program window at $8000-$BFFF and a window at $C000-$FFFF that is always tied to the final program bank. The picture side sees four independent 2 KiB character windows that cover the 8 KiB pattern space.

A fifth output, the nametable VRAM A10 line, is driven from a source that a 2-bit mirroring field selects. That source can be either of two picture-address bits, or a constant for the two single-screen layouts. Two of the decoded slots belong to a cycle counter that lives outside this block. For those slots the block only raises a write strobe while the write is presented, and the counter uses it to load or to control itself.

Top module: `cart_bank_mapper`

## Requirements
- R1: A register write takes place only when `cpu_wr_i` is 1, `cpu_addr_i[15]` is 1 and `cpu_addr_i[11]` is 1. `cpu_addr_i[14:12]` picks the slot and bits 10:0 are don't-care, so $8BCD writes the same slot as $8800.
- R2: Slots 0 to 3 ($8800, $9800, $A800, $B800) each store the full data byte as character bank 0 to 3.
- R3: `chr_addr_o` equals {character bank n, `ppu_addr_i[10:0]`}, where n = `ppu_addr_i[12:11]`.
- R4: Slot 7 ($F800) stores the low `PRG_BANK_W` data bits as the program bank. When `cpu_addr_i[14]` is 0, `prg_addr_o` equals {program bank, `cpu_addr_i[13:0]`}.
- R5: When `cpu_addr_i[14]` is 1, `prg_addr_o` equals {`PRG_BANKS`-1, `cpu_addr_i[13:0]`}, whatever the program bank register holds.
- R6: Slot 6 ($E800) stores data bits 1:0 as the mirroring mode. Mode 0 drives `vram_a10_o` from `ppu_addr_i[10]`, mode 1 from `ppu_addr_i[11]`, mode 2 drives 0 and mode 3 drives 1. Data bits 7:2 have no effect.
- R7: Writes that fail R1 change no bank or mirroring state. This covers addresses with bit 15 clear and addresses in the gaps with bit 11 clear.
- R8: When `rst_ni` is low, all character banks, the program bank and the mirroring mode are cleared to 0, asynchronously.
- R9: `ctr_load_we_o` is 1 exactly while an R1-qualified write addresses slot 4 ($C800). `ctr_ctrl_we_o` is 1 exactly while such a write addresses slot 5 ($D800). These slots change no bank or mirroring state.
- R10: A captured value first appears on the address outputs after the rising clock edge that samples the write, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | DATA_W | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe |
| ppu_addr_i | input | 13 | Picture-processor address bits 12:0 |
| prg_addr_o | output | PRG_BANK_W+14 | Program ROM address |
| chr_addr_o | output | DATA_W+11 | Character ROM address |
| vram_a10_o | output | 1 | Nametable VRAM A10 |
| ctr_load_we_o | output | 1 | Write strobe for the external counter value slot |
| ctr_ctrl_we_o | output | 1 | Write strobe for the external counter control slot |

## Verification
Each character bank gets a distinct byte, and the readout steps through all four picture windows with a fixed low-address pattern, so a swapped window select or a truncated bank would show up as the wrong value. The program path is read with bit 14 both clear and set, using bank values whose low bits differ from the fixed last bank. This separates the switchable window from the pinned one and checks that the upper data bits are dropped. All four mirroring modes are written with junk in the upper data bits and then read at the four nametable quadrants, which tells the two address-driven modes apart from the two constant modes. Writes are also sent to aliased addresses, to the low half of the address space, to the bit-11 gaps and to the counter slots, and each time the full bank state is read back to confirm nothing else moved.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

  // slot index = cpu_addr[14:12] of a qualified write
  typedef enum logic [3:0] {
    SEL_NONE     = 4'h0,
    SEL_CHR0     = 4'h1,
    SEL_CHR1     = 4'h2,
    SEL_CHR2     = 4'h3,
    SEL_CHR3     = 4'h4,
    SEL_CTR_LOAD = 4'h5,
    SEL_CTR_CTRL = 4'h6,
    SEL_MIRROR   = 4'h7,
    SEL_PRG      = 4'h8
  } reg_sel_e;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mir_mode_e;

  localparam int unsigned CHR_SLOTS = 4;
  localparam int unsigned PRG_OFF_W = 14;
  localparam int unsigned CHR_OFF_W = 11;

endpackage

// File: rtl/cart_mapper_decode.sv
module cart_mapper_decode
  import cart_mapper_pkg::*;
(
  input  logic [15:11] cpu_addr_hi_i,
  input  logic         cpu_wr_i,
  output reg_sel_e     sel_o,
  output logic         ctr_load_we_o,
  output logic         ctr_ctrl_we_o
);

  logic hit;

  assign hit = cpu_wr_i & cpu_addr_hi_i[15] & cpu_addr_hi_i[11];

  always_comb begin
    sel_o = SEL_NONE;
    if (hit) begin
      unique case (cpu_addr_hi_i[14:12])
        3'd0: sel_o = SEL_CHR0;
        3'd1: sel_o = SEL_CHR1;
        3'd2: sel_o = SEL_CHR2;
        3'd3: sel_o = SEL_CHR3;
        3'd4: sel_o = SEL_CTR_LOAD;
        3'd5: sel_o = SEL_CTR_CTRL;
        3'd6: sel_o = SEL_MIRROR;
        default: sel_o = SEL_PRG;
      endcase
    end
  end

  assign ctr_load_we_o = (sel_o == SEL_CTR_LOAD);
  assign ctr_ctrl_we_o = (sel_o == SEL_CTR_CTRL);

endmodule

// File: rtl/cart_mapper_regs.sv
module cart_mapper_regs
  import cart_mapper_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PRG_BANK_W = 3
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  reg_sel_e                            sel_i,
  input  logic [DATA_W-1:0]                   data_i,
  output logic [CHR_SLOTS-1:0][DATA_W-1:0]    chr_bank_o,
  output logic [PRG_BANK_W-1:0]               prg_bank_o,
  output mir_mode_e                           mir_mode_o
);

  for (genvar g = 0; g < CHR_SLOTS; g++) begin : g_chr
    localparam reg_sel_e MY_SEL = reg_sel_e'(4'(int'(SEL_CHR0) + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              chr_bank_o[g] <= '0;
      else if (sel_i == MY_SEL) chr_bank_o[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               prg_bank_o <= '0;
    else if (sel_i == SEL_PRG) prg_bank_o <= data_i[PRG_BANK_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mir_mode_o <= MIR_VERT;
    else if (sel_i == SEL_MIRROR) mir_mode_o <= mir_mode_e'(data_i[1:0]);
  end

endmodule

// File: rtl/cart_mapper_xlate.sv
module cart_mapper_xlate
  import cart_mapper_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PRG_BANKS  = 8,
  parameter int unsigned PRG_BANK_W = 3
) (
  input  logic [14:0]                          cpu_addr_i,
  input  logic [12:0]                          ppu_addr_i,
  input  logic [CHR_SLOTS-1:0][DATA_W-1:0]     chr_bank_i,
  input  logic [PRG_BANK_W-1:0]                prg_bank_i,
  input  mir_mode_e                            mir_mode_i,
  output logic [PRG_BANK_W+PRG_OFF_W-1:0]      prg_addr_o,
  output logic [DATA_W+CHR_OFF_W-1:0]          chr_addr_o,
  output logic                                 vram_a10_o
);

  localparam logic [PRG_BANK_W-1:0] LAST_BANK = PRG_BANK_W'(PRG_BANKS - 1);

  logic [PRG_BANK_W-1:0] prg_sel;
  logic [1:0]            chr_slot;

  assign prg_sel    = cpu_addr_i[14] ? LAST_BANK : prg_bank_i;
  assign prg_addr_o = {prg_sel, cpu_addr_i[PRG_OFF_W-1:0]};

  assign chr_slot   = ppu_addr_i[12:11];
  assign chr_addr_o = {chr_bank_i[chr_slot], ppu_addr_i[CHR_OFF_W-1:0]};

  always_comb begin
    unique case (mir_mode_i)
      MIR_VERT:   vram_a10_o = ppu_addr_i[10];
      MIR_HORZ:   vram_a10_o = ppu_addr_i[11];
      MIR_ONE_LO: vram_a10_o = 1'b0;
      default:    vram_a10_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_mapper_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PRG_BANKS  = 8,
  localparam int unsigned PRG_BANK_W = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [15:0]                        cpu_addr_i,
  input  logic [DATA_W-1:0]                  cpu_data_i,
  input  logic                               cpu_wr_i,
  input  logic [12:0]                        ppu_addr_i,
  output logic [PRG_BANK_W+PRG_OFF_W-1:0]    prg_addr_o,
  output logic [DATA_W+CHR_OFF_W-1:0]        chr_addr_o,
  output logic                               vram_a10_o,
  output logic                               ctr_load_we_o,
  output logic                               ctr_ctrl_we_o
);

  reg_sel_e                          wr_sel;
  logic [CHR_SLOTS-1:0][DATA_W-1:0]  chr_bank_q;
  logic [PRG_BANK_W-1:0]             prg_bank_q;
  mir_mode_e                         mir_mode_q;

  cart_mapper_decode u_decode (
    .cpu_addr_hi_i (cpu_addr_i[15:11]),
    .cpu_wr_i      (cpu_wr_i),
    .sel_o         (wr_sel),
    .ctr_load_we_o (ctr_load_we_o),
    .ctr_ctrl_we_o (ctr_ctrl_we_o)
  );

  cart_mapper_regs #(
    .DATA_W     (DATA_W),
    .PRG_BANK_W (PRG_BANK_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (wr_sel),
    .data_i     (cpu_data_i),
    .chr_bank_o (chr_bank_q),
    .prg_bank_o (prg_bank_q),
    .mir_mode_o (mir_mode_q)
  );

  cart_mapper_xlate #(
    .DATA_W     (DATA_W),
    .PRG_BANKS  (PRG_BANKS),
    .PRG_BANK_W (PRG_BANK_W)
  ) u_xlate (
    .cpu_addr_i (cpu_addr_i[14:0]),
    .ppu_addr_i (ppu_addr_i),
    .chr_bank_i (chr_bank_q),
    .prg_bank_i (prg_bank_q),
    .mir_mode_i (mir_mode_q),
    .prg_addr_o (prg_addr_o),
    .chr_addr_o (chr_addr_o),
    .vram_a10_o (vram_a10_o)
  );

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PRG_BANKS  = 8,
  parameter int unsigned PRG_BANK_W = 3
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [15:0]                        cpu_addr_i,
  input logic [DATA_W-1:0]                  cpu_data_i,
  input logic                               cpu_wr_i,
  input logic [12:0]                        ppu_addr_i,
  input logic [PRG_BANK_W+13:0]             prg_addr_o,
  input logic [DATA_W+10:0]                 chr_addr_o,
  input logic                               vram_a10_o,
  input logic                               ctr_load_we_o,
  input logic                               ctr_ctrl_we_o,
  input logic [3:0][DATA_W-1:0]             chr_bank_i,
  input logic [PRG_BANK_W-1:0]              prg_bank_i,
  input logic [1:0]                         mir_i
);

  localparam logic [PRG_BANK_W-1:0] LAST_BANK = PRG_BANK_W'(PRG_BANKS - 1);

  logic legal_wr;
  assign legal_wr = cpu_wr_i & cpu_addr_i[15] & cpu_addr_i[11];

  for (genvar g = 0; g < 4; g++) begin : g_chr
    localparam logic [4:0] TAG = 5'(17 + 2 * g);
    // R2
    chr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      legal_wr && cpu_addr_i[15:11] == TAG |=> chr_bank_i[g] == $past(cpu_data_i));
  end

  // R4
  prg_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_wr && cpu_addr_i[14:12] == 3'd7 |=> prg_bank_i == $past(cpu_data_i[PRG_BANK_W-1:0]));

  // R5
  fixed_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[14] |-> prg_addr_o[PRG_BANK_W+13:14] == LAST_BANK);

  // R3
  chr_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_addr_o[DATA_W+10:11] == chr_bank_i[ppu_addr_i[12:11]]);

  // R6
  one_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mir_i == 2'd2 |-> !vram_a10_o);

  // R6
  one_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mir_i == 2'd3 |-> vram_a10_o);

  // R7
  no_side_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_wr |=> $stable(chr_bank_i) && $stable(prg_bank_i) && $stable(mir_i));

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctr_load_we_o, ctr_ctrl_we_o}));

  // R9
  strobe_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctr_load_we_o || ctr_ctrl_we_o) |-> legal_wr);

  // R9
  ctr_slot_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctr_load_we_o || ctr_ctrl_we_o) |=> $stable(chr_bank_i) && $stable(prg_bank_i) && $stable(mir_i));

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
  .DATA_W     (DATA_W),
  .PRG_BANKS  (PRG_BANKS),
  .PRG_BANK_W (PRG_BANK_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_addr_i    (cpu_addr_i),
  .cpu_data_i    (cpu_data_i),
  .cpu_wr_i      (cpu_wr_i),
  .ppu_addr_i    (ppu_addr_i),
  .prg_addr_o    (prg_addr_o),
  .chr_addr_o    (chr_addr_o),
  .vram_a10_o    (vram_a10_o),
  .ctr_load_we_o (ctr_load_we_o),
  .ctr_ctrl_we_o (ctr_ctrl_we_o),
  .chr_bank_i    (chr_bank_q),
  .prg_bank_i    (prg_bank_q),
  .mir_i         (mir_mode_q)
);

// File: tb/cart_bank_mapper_tb_top.sv
module cart_bank_mapper_tb_top;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned BANKS  = 8;
  localparam int unsigned BW     = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       cpu_addr = '0;
  logic [DATA_W-1:0] cpu_data = '0;
  logic              cpu_wr = 1'b0;
  logic [12:0]       ppu_addr = '0;
  logic [BW+13:0]    prg_addr;
  logic [DATA_W+10:0] chr_addr;
  logic              vram_a10;
  logic              ld_we;
  logic              ctl_we;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]    chr_m [4];
  logic [BW-1:0] prg_m;
  logic [1:0]    mir_m;

  always #10 clk = ~clk;

  cart_bank_mapper #(.DATA_W(DATA_W), .PRG_BANKS(BANKS)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cpu_addr_i    (cpu_addr),
    .cpu_data_i    (cpu_data),
    .cpu_wr_i      (cpu_wr),
    .ppu_addr_i    (ppu_addr),
    .prg_addr_o    (prg_addr),
    .chr_addr_o    (chr_addr),
    .vram_a10_o    (vram_a10),
    .ctr_load_we_o (ld_we),
    .ctr_ctrl_we_o (ctl_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference update from the requirement text
  task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
    if (a[15] && a[11]) begin
      case (a[14:12])
        3'd0, 3'd1, 3'd2, 3'd3: chr_m[a[13:12]] = d;
        3'd6: mir_m = d[1:0];
        3'd7: prg_m = d[BW-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic verify_state(input string req);
    for (int s = 0; s < 4; s++) begin
      ppu_addr = {s[1:0], 11'h5A3};
      #1;
      check(req, 32'(chr_addr), 32'({chr_m[s], 11'h5A3}));
    end
    cpu_addr = 16'h9234;
    #1;
    check(req, 32'(prg_addr), 32'({prg_m, 14'h1234}));
    for (int q = 0; q < 4; q++) begin
      ppu_addr = 13'({q[1:0], 10'h0});
      #1;
      case (mir_m)
        2'd0: check(req, 32'(vram_a10), 32'(q[0]));
        2'd1: check(req, 32'(vram_a10), 32'(q[1]));
        2'd2: check(req, 32'(vram_a10), 32'd0);
        default: check(req, 32'(vram_a10), 32'd1);
      endcase
    end
  endtask

  task automatic t_reset;
    foreach (chr_m[i]) chr_m[i] = '0;
    prg_m = '0; mir_m = '0;
    verify_state("R8 reset");
    cpu_write(16'h8800, 8'h3C);
    cpu_write(16'hF800, 8'h05);
    cpu_write(16'hE800, 8'h03);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    foreach (chr_m[i]) chr_m[i] = '0;
    prg_m = '0; mir_m = '0;
    verify_state("R8 async reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_chr_banks;
    cpu_write(16'h8800, 8'hA5);
    cpu_write(16'h9800, 8'h5A);
    cpu_write(16'hA800, 8'hFF);
    cpu_write(16'hB800, 8'h81);
    verify_state("R2 R3 chr banks");
    cpu_write(16'h8BCD, 8'h42);
    cpu_write(16'hBFFF, 8'h17);
    verify_state("R1 alias write");
    ppu_addr = 13'h1FFF;
    #1;
    check("R3 top of window", 32'(chr_addr), 32'({8'h17, 11'h7FF}));
  endtask

  task automatic t_prg_window;
    cpu_write(16'hF800, 8'hFD);
    cpu_addr = 16'h8000; #1;
    check("R4 switch window", 32'(prg_addr), 32'({3'd5, 14'h0000}));
    cpu_addr = 16'hBFFF; #1;
    check("R4 switch window end", 32'(prg_addr), 32'({3'd5, 14'h3FFF}));
    cpu_addr = 16'hC000; #1;
    check("R5 fixed window", 32'(prg_addr), 32'({3'd7, 14'h0000}));
    cpu_addr = 16'hFABC; #1;
    check("R5 fixed window", 32'(prg_addr), 32'({3'd7, 14'h3ABC}));
    cpu_write(16'hF800, 8'h02);
    cpu_addr = 16'hE001; #1;
    check("R5 fixed after rewrite", 32'(prg_addr), 32'({3'd7, 14'h2001}));
    verify_state("R4 prg state");
  endtask

  task automatic t_mirroring;
    for (int m = 0; m < 4; m++) begin
      cpu_write(16'hE800, {6'b101011, m[1:0]});
      verify_state("R6 mirroring");
    end
  endtask

  task automatic t_ignored;
    cpu_write(16'h0800, 8'h11);
    cpu_write(16'h7800, 8'h22);
    cpu_write(16'h8000, 8'h33);
    cpu_write(16'h9000, 8'h44);
    cpu_write(16'hE000, 8'h02);
    cpu_write(16'hF000, 8'h06);
    verify_state("R7 ignored writes");
    @(negedge clk);
    cpu_addr = 16'h8800; cpu_data = 8'h99; cpu_wr = 1'b0;
    @(negedge clk);
    verify_state("R1 no strobe");
  endtask

  task automatic t_counter_slots;
    @(negedge clk);
    cpu_addr = 16'hC800; cpu_data = 8'h12; cpu_wr = 1'b1; #1;
    check("R9 load strobe", 32'({ld_we, ctl_we}), 32'b10);
    cpu_addr = 16'hD9AB; #1;
    check("R9 ctrl strobe", 32'({ld_we, ctl_we}), 32'b01);
    cpu_addr = 16'hE800; cpu_wr = 1'b0; #1;
    check("R9 no strobe idle", 32'({ld_we, ctl_we}), 32'b00);
    cpu_addr = 16'h4800; cpu_wr = 1'b1; #1;
    check("R9 no strobe low half", 32'({ld_we, ctl_we}), 32'b00);
    cpu_addr = 16'hC000; #1;
    check("R9 no strobe gap", 32'({ld_we, ctl_we}), 32'b00);
    cpu_addr = 16'hD800; cpu_data = 8'h10;
    @(negedge clk);
    cpu_wr = 1'b0;
    verify_state("R9 counter slots quiet");
  endtask

  task automatic t_timing;
    @(negedge clk);
    ppu_addr = 13'h0800;
    cpu_addr = 16'h9800; cpu_data = 8'hC3; cpu_wr = 1'b1;
    #5;
    check("R10 before edge", 32'(chr_addr), 32'({chr_m[1], 11'h000}));
    @(posedge clk);
    #2;
    cpu_wr = 1'b0;
    model_wr(16'h9800, 8'hC3);
    check("R10 after edge", 32'(chr_addr), 32'({8'hC3, 11'h000}));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_chr_banks();
    t_prg_window();
    t_mirroring();
    t_ignored();
    t_counter_slots();
    t_timing();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule